// File: doc/BRIEF.md
# DMA Channel Interrupt Status Aggregator

This block gathers interrupt events from up to sixteen DMA channel engines and presents them to software as a small set of 32-bit registers. Each channel engine reports an event as a one-cycle pulse that carries the channel number and one of four event classes. The four classes are completion of a whole transfer chain, completion of a single chain node, and two independent error kinds. Every class keeps three things: a latched raw bit per channel, a per-channel enable mask, and a masked view that is the AND of the two.

A summary word flags each channel that has any enabled event pending in any class. A single interrupt line is the registered OR of that summary. Software clears latched events by writing ones to the raw registers. The same register port also exposes two other registers. One is a live per-channel busy word that comes straight from the channel engines. The other is a plain 32-bit priority storage register.

Class encoding on `evt_class`: 0 = chain done, 1 = node done, 2 = error A, 3 = error B. For class k, the masked view is at offset 0x004+4k, the mask is at 0x018+4k and the raw bits are at 0x600+8k.

Top module: `dma_irq_agg`

## Requirements
- R1: An `evt_valid` pulse with class k and channel c sets bit c of class k's raw register (offset 0x600+8k) at that clock edge. It leaves every other bit alone.
- R2: A write to a raw register clears each bit written as 1. Bits written as 0 keep their value.
- R3: When an event and a clearing write target the same raw bit in the same cycle, the bit ends up set.
- R4: The mask register of class k (offset 0x018+4k) stores the low 16 bits of a write and reads them back. It resets to 0.
- R5: The masked view of class k (offset 0x004+4k) reads as raw AND mask for that class.
- R6: The summary register (offset 0x000) has bit c set exactly when channel c has a masked event pending in at least one class.
- R7: `irq_o` is high in the cycle after any summary bit was set, and low in the cycle after all summary bits were clear.
- R8: The busy register (offset 0x690) reads as the `chan_busy` input sampled at the read's address cycle.
- R9: The priority register (offset 0x688) holds a full 32-bit written value and resets to 0.
- R10: Reads of unmapped offsets return 0. Writes to unmapped offsets, and to the summary, masked and busy offsets, change no register.
- R11: `reg_rdata` shows the register selected by `reg_addr` one cycle after the address is presented. Bits above the channel count read as 0. After reset every register reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | One-cycle event pulse from a channel engine |
| evt_class | input | 2 | Event class (0 chain done, 1 node done, 2 error A, 3 error B) |
| evt_chan | input | 4 | Channel number of the event |
| chan_busy | input | 16 | Live per-channel running flags |
| reg_addr | input | 12 | Register byte offset |
| reg_wen | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| irq_o | output | 1 | Combined interrupt line |

## Verification
The bench aims at the cycle in which a node or error event arrives together with a clearing write to the same bit. A design that lets the clear win would lose that event, and a later read of the raw register would show 0. It also writes zeros and stray upper bits into the raw registers. A design that treats those registers as plain storage would wipe pending events or latch bits beyond the channel count. Writes to unmapped and read-only offsets are followed by a full read sweep, so a decoder that aliases addresses shows up as a changed mask or priority value. The interrupt line is sampled one cycle after each mask change, so a line that does not honour the masks, or that drops a class from the OR, is caught.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int NCLS   = 4;

    typedef enum logic [1:0] {
        EVC_CHAIN = 2'd0,
        EVC_NODE  = 2'd1,
        EVC_ERRA  = 2'd2,
        EVC_ERRB  = 2'd3
    } evt_class_e;

    // Base offsets; per-class strides are 4 (views, masks) and 8 (raw)
    localparam logic [ADDR_W-1:0] OFS_SUMMARY = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_MSTAT0  = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_MASK0   = 12'h018;
    localparam logic [ADDR_W-1:0] OFS_RAW0    = 12'h600;
    localparam logic [ADDR_W-1:0] OFS_PRIO    = 12'h688;
    localparam logic [ADDR_W-1:0] OFS_BUSY    = 12'h690;

endpackage

// File: rtl/irq_class_bank.sv
module irq_class_bank #(
    parameter int NUM_CH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] set_vec,
    input  logic              clr_we,
    input  logic              mask_we,
    input  logic [NUM_CH-1:0] wdata,
    output logic [NUM_CH-1:0] raw_o,
    output logic [NUM_CH-1:0] mask_o,
    output logic [NUM_CH-1:0] masked_o
);

    typedef struct packed {
        logic [NUM_CH-1:0] raw;
        logic [NUM_CH-1:0] mask;
    } bank_t;

    bank_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr_we) begin
            s_d.raw = s_q.raw & ~wdata;
        end
        // a new event is applied after the clear so it takes priority
        s_d.raw = s_d.raw | set_vec;
        if (mask_we) begin
            s_d.mask = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign raw_o    = s_q.raw;
    assign mask_o   = s_q.mask;
    assign masked_o = s_q.raw & s_q.mask;

    assert_event_latch_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((raw_o & $past(set_vec)) == $past(set_vec)));

    assert_clear_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((raw_o & $past(wdata & ~set_vec)) == '0));

    assert_no_spurious_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we |=> ((raw_o & $past(raw_o)) == $past(raw_o)));

    assert_event_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && |(set_vec & wdata)) |=>
            ((raw_o & $past(set_vec & wdata)) == $past(set_vec & wdata)));

    assert_mask_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> (mask_o == $past(wdata)));

    assert_mask_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we |=> $stable(mask_o));

endmodule

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
    import dma_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wen,
    output logic [NCLS-1:0]   raw_clr_we,
    output logic [NCLS-1:0]   mask_we,
    output logic              prio_we
);

    logic [NCLS-1:0] raw_hit;
    logic [NCLS-1:0] mask_hit;

    for (genvar k = 0; k < NCLS; k++) begin : g_cls
        assign raw_hit[k]  = (addr == ADDR_W'(OFS_RAW0  + 8 * k));
        assign mask_hit[k] = (addr == ADDR_W'(OFS_MASK0 + 4 * k));
    end

    assign raw_clr_we = wen ? raw_hit  : '0;
    assign mask_we    = wen ? mask_hit : '0;
    assign prio_we    = wen && (addr == OFS_PRIO);

    assert_single_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({raw_clr_we, mask_we, prio_we}));

    assert_no_write_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wen |-> ({raw_clr_we, mask_we, prio_we} == '0));

endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
    import dma_irq_pkg::*;
#(
    parameter int NUM_CH = 16
) (
    input  logic [ADDR_W-1:0]           addr,
    input  logic [NCLS-1:0][NUM_CH-1:0] raw,
    input  logic [NCLS-1:0][NUM_CH-1:0] mask,
    input  logic [NCLS-1:0][NUM_CH-1:0] masked,
    input  logic [NUM_CH-1:0]           summary,
    input  logic [NUM_CH-1:0]           busy,
    input  logic [DATA_W-1:0]           prio,
    output logic [DATA_W-1:0]           rdata
);

    always_comb begin
        rdata = '0;
        if (addr == OFS_SUMMARY) rdata = DATA_W'(summary);
        if (addr == OFS_BUSY)    rdata = DATA_W'(busy);
        if (addr == OFS_PRIO)    rdata = prio;
        for (int k = 0; k < NCLS; k++) begin
            if (addr == ADDR_W'(OFS_MSTAT0 + 4 * k)) rdata = DATA_W'(masked[k]);
            if (addr == ADDR_W'(OFS_MASK0  + 4 * k)) rdata = DATA_W'(mask[k]);
            if (addr == ADDR_W'(OFS_RAW0   + 8 * k)) rdata = DATA_W'(raw[k]);
        end
    end

endmodule

// File: rtl/dma_irq_agg.sv
module dma_irq_agg
    import dma_irq_pkg::*;
#(
    parameter int NUM_CH = 16,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid,
    input  logic [1:0]        evt_class,
    input  logic [CH_W-1:0]   evt_chan,
    input  logic [NUM_CH-1:0] chan_busy,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wen,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_o
);

    typedef struct packed {
        logic [DATA_W-1:0] prio;
        logic [DATA_W-1:0] rdata;
        logic              irq;
    } top_t;

    top_t s_d, s_q;

    logic [NCLS-1:0]             raw_clr_we;
    logic [NCLS-1:0]             mask_we;
    logic                        prio_we;
    logic [NCLS-1:0][NUM_CH-1:0] set_vec;
    logic [NCLS-1:0][NUM_CH-1:0] raw;
    logic [NCLS-1:0][NUM_CH-1:0] mask;
    logic [NCLS-1:0][NUM_CH-1:0] masked;
    logic [NUM_CH-1:0]           summary;
    logic [DATA_W-1:0]           mux_rdata;
    logic                        chan_ok;

    assign chan_ok = (32'(evt_chan) < NUM_CH);

    irq_addr_decode u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (reg_addr),
        .wen        (reg_wen),
        .raw_clr_we (raw_clr_we),
        .mask_we    (mask_we),
        .prio_we    (prio_we)
    );

    for (genvar k = 0; k < NCLS; k++) begin : g_bank
        assign set_vec[k] = (evt_valid && chan_ok && (evt_class == 2'(k)))
                          ? (NUM_CH'(1) << evt_chan) : '0;

        irq_class_bank #(.NUM_CH(NUM_CH)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_vec  (set_vec[k]),
            .clr_we   (raw_clr_we[k]),
            .mask_we  (mask_we[k]),
            .wdata    (reg_wdata[NUM_CH-1:0]),
            .raw_o    (raw[k]),
            .mask_o   (mask[k]),
            .masked_o (masked[k])
        );
    end

    always_comb begin
        summary = '0;
        for (int k = 0; k < NCLS; k++) begin
            summary = summary | masked[k];
        end
    end

    irq_read_mux #(.NUM_CH(NUM_CH)) u_mux (
        .addr    (reg_addr),
        .raw     (raw),
        .mask    (mask),
        .masked  (masked),
        .summary (summary),
        .busy    (chan_busy),
        .prio    (s_q.prio),
        .rdata   (mux_rdata)
    );

    always_comb begin
        s_d       = s_q;
        s_d.rdata = mux_rdata;
        s_d.irq   = |summary;
        if (prio_we) begin
            s_d.prio = reg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign reg_rdata = s_q.rdata;
    assign irq_o     = s_q.irq;

    assert_irq_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|summary) |=> irq_o);

    assert_irq_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(|summary) |=> !irq_o);

    assert_prio_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        prio_we |=> (s_q.prio == $past(reg_wdata)));

    assert_prio_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !prio_we |=> $stable(s_q.prio));

    assert_upper_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr != OFS_PRIO) |=> (reg_rdata[DATA_W-1:NUM_CH] == '0));

endmodule

// File: tb/sim_dma_irq_agg.sv
module sim_dma_irq_agg;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_valid = 1'b0;
    logic [1:0]  evt_class = '0;
    logic [3:0]  evt_chan = '0;
    logic [15:0] chan_busy = '0;
    logic [11:0] reg_addr = '0;
    logic        reg_wen = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_o;

    int tests = 0;
    int fails = 0;

    logic [15:0] m_raw  [4];
    logic [15:0] m_mask [4];
    logic [31:0] m_prio;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_irq_agg #(.NUM_CH(NCH)) u0 (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_class(evt_class),
        .evt_chan(evt_chan), .chan_busy(chan_busy), .reg_addr(reg_addr),
        .reg_wen(reg_wen), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    function automatic logic [15:0] m_summary();
        logic [15:0] s = '0;
        for (int k = 0; k < 4; k++) s |= m_raw[k] & m_mask[k];
        return s;
    endfunction

    function automatic logic [31:0] exp_read(logic [11:0] a);
        if (a == 12'h000) return {16'h0, m_summary()};
        if (a == 12'h688) return m_prio;
        if (a == 12'h690) return {16'h0, chan_busy};
        for (int k = 0; k < 4; k++) begin
            if (a == 12'(12'h004 + 4*k)) return {16'h0, m_raw[k] & m_mask[k]};
            if (a == 12'(12'h018 + 4*k)) return {16'h0, m_mask[k]};
            if (a == 12'(12'h600 + 8*k)) return {16'h0, m_raw[k]};
        end
        return 32'h0;
    endfunction

    function automatic logic [11:0] mapped_addr(int i);
        case (i)
            0: return 12'h000;  1: return 12'h004;  2: return 12'h008;
            3: return 12'h00c;  4: return 12'h010;  5: return 12'h018;
            6: return 12'h01c;  7: return 12'h020;  8: return 12'h024;
            9: return 12'h600; 10: return 12'h608; 11: return 12'h610;
            12: return 12'h618; 13: return 12'h688; default: return 12'h690;
        endcase
    endfunction

    function automatic logic is_mapped(logic [11:0] a);
        for (int i = 0; i < 15; i++) if (mapped_addr(i) == a) return 1'b1;
        return 1'b0;
    endfunction

    function automatic void model_write(logic [11:0] a, logic [31:0] d);
        if (a == 12'h688) m_prio = d;
        for (int k = 0; k < 4; k++) begin
            if (a == 12'(12'h018 + 4*k)) m_mask[k] = d[15:0];
            if (a == 12'(12'h600 + 8*k)) m_raw[k] = m_raw[k] & ~d[15:0];
        end
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
        @(negedge clk);
        reg_wen = 1'b0;
        model_write(a, d);
    endtask

    task automatic ev(logic [1:0] c, logic [3:0] ch);
        @(negedge clk);
        evt_valid = 1'b1; evt_class = c; evt_chan = ch;
        @(negedge clk);
        evt_valid = 1'b0;
        m_raw[c][ch] = 1'b1;
    endtask

    task automatic ev_and_clear(logic [1:0] c, logic [3:0] ch, logic [15:0] clr);
        @(negedge clk);
        evt_valid = 1'b1; evt_class = c; evt_chan = ch;
        reg_addr = 12'(12'h600 + 8*c); reg_wdata = {16'h0, clr}; reg_wen = 1'b1;
        @(negedge clk);
        evt_valid = 1'b0; reg_wen = 1'b0;
        m_raw[c] = (m_raw[c] & ~clr);
        m_raw[c][ch] = 1'b1;
    endtask

    task automatic rd_chk(logic [11:0] a, string req);
        logic [31:0] e;
        @(negedge clk);
        reg_addr = a;
        e = exp_read(a);
        @(negedge clk);
        chk(req, reg_rdata, e);
    endtask

    task automatic irq_chk(string req);
        @(negedge clk);
        chk(req, {31'h0, irq_o}, {31'h0, |m_summary()});
    endtask

    task automatic sweep(string req);
        for (int i = 0; i < 15; i++) rd_chk(mapped_addr(i), req);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [11:0] a;
        int unsigned seed;
        seed = $urandom(32'h5eed_1234);
        for (int k = 0; k < 4; k++) begin m_raw[k] = '0; m_mask[k] = '0; end
        m_prio = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state: every register reads 0 (busy input held 0)
        sweep("R11 reset");
        irq_chk("R7 reset");

        // R1 latching with masks off; R7 stays low
        ev(2'd0, 4'd3);
        rd_chk(12'h600, "R1 raw chain");
        rd_chk(12'h004, "R5 masked off");
        irq_chk("R7 masked off");
        // R4 enable all channels of class 0, irq follows
        wr(12'h018, 32'hffff_ffff);
        rd_chk(12'h018, "R4 mask upper dropped");
        irq_chk("R7 rise");
        rd_chk(12'h000, "R6 summary");
        // R2 writing zeros does nothing
        wr(12'h600, 32'h0000_0000);
        rd_chk(12'h600, "R2 zero write");
        wr(12'h600, 32'h0000_0008);
        rd_chk(12'h600, "R2 clear");
        irq_chk("R7 fall");
        // R3 event and clear on the same bit
        ev(2'd1, 4'd15);
        ev_and_clear(2'd1, 4'd15, 16'hffff);
        rd_chk(12'h608, "R3 event wins");
        ev_and_clear(2'd2, 4'd0, 16'h0002);
        rd_chk(12'h610, "R3 other bit");
        // R9 priority full width
        wr(12'h688, 32'hdead_beef);
        rd_chk(12'h688, "R9 prio");
        // R10 unmapped and read-only writes
        wr(12'h000, 32'hffff_ffff);
        wr(12'h008, 32'hffff_ffff);
        wr(12'h690, 32'hffff_ffff);
        wr(12'h604, 32'hffff_ffff);
        wr(12'h028, 32'hffff_ffff);
        wr(12'h68c, 32'h1234_5678);
        rd_chk(12'h604, "R10 unmapped read");
        rd_chk(12'hffc, "R10 unmapped read");
        sweep("R10 after ignored writes");
        // R8 busy readback
        chan_busy = 16'ha5c3;
        rd_chk(12'h690, "R8 busy");

        // constrained random mix
        for (int it = 0; it < 800; it++) begin
            int op;
            op = int'($urandom % 8);
            case (op)
                0, 1: ev(2'($urandom), 4'($urandom));
                2: begin
                    a = mapped_addr(int'($urandom % 15));
                    wr(a, $urandom);
                end
                3: begin
                    a = 12'($urandom) & 12'hffc;
                    if (!is_mapped(a)) wr(a, $urandom);
                end
                4: ev_and_clear(2'($urandom), 4'($urandom), 16'($urandom));
                5: chan_busy = 16'($urandom);
                6: irq_chk("R7 random");
                default: rd_chk(mapped_addr(int'($urandom % 15)), "R5 R6 random read");
            endcase
        end
        sweep("R1 R2 R4 final sweep");
        irq_chk("R7 final");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule